// File: doc/BRIEF.md
# SIMT Branch Divergence Controller

This block steers control flow for a warp of threads that all run from one shared program counter. One fetched and decoded instruction goes to every active thread at once. On a branch, the block combines each thread's condition bit with the current active mask. If every active thread goes the same way, the branch becomes a plain jump or a plain fall-through, and the mask does not change. If the active threads disagree, the warp splits. The taken group runs first. The other group waits on a hardware stack and runs once the first group reaches the reconvergence address. When both groups have reached that address, the warp joins again under the mask it had before the split.

Each stack entry holds four things: the reconvergence address, the start address and mask of the deferred group, the mask to restore, and a phase bit that records which group is running. Because of this, conditionals can nest up to the stack depth. A divergent branch that arrives with the stack full sets a sticky overflow flag and is dropped. A launch command loads a new PC and mask, empties the stack and clears the flag. The block's outputs are the current PC and the current execution mask. Fetch and the datapath consume these outputs.

Top module: `simt_diverge_ctrl`

## Requirements
- R1: During reset (rst_n low at a clock edge) the PC becomes 0, the mask becomes all ones, the stack depth becomes 0 and the overflow flag becomes 0.
- R2: A step with is_branch_i low advances the PC by one and leaves the mask unchanged, provided the stack top's reconvergence address is not hit.
- R3: A branch is uniform when (cond_i & mask) equals the mask or equals zero. A uniform branch goes to target_i in the first case and to PC+1 in the second, and it leaves the mask and the depth unchanged.
- R4: A divergent branch with room on the stack pushes one entry, moves the PC to target_i and sets the mask to cond_i & mask. The depth grows by one.
- R5: When the next PC of the running group equals the top entry's reconvergence address and the deferred group has not yet run, the PC moves to the branch address plus one and the mask becomes mask_at_branch & ~cond_i.
- R6: When the second group reaches the reconvergence address, the entry is popped, the PC stays at that address and the mask is restored to its value before the branch.
- R7: Nested divergence unwinds innermost first. Threads inactive when a branch is evaluated never become active in either of its paths.
- R8: A divergent branch on a full stack sets overflow_o, which stays set until launch. The PC advances by one and the mask and depth do not change.
- R9: A branch evaluated under an all-zero mask falls through to PC+1 and pushes nothing.
- R10: With the stack empty, reaching any address changes neither the mask nor the depth, so a pop of an empty stack cannot occur.
- R11: A launch loads launch_pc_i and launch_mask_i, sets the depth to 0 and clears overflow_o, taking priority over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| launch_i | input | 1 | Start a new program: load PC and mask, empty the stack |
| launch_pc_i | input | PC_W (16) | Start address for launch |
| launch_mask_i | input | WARP (8) | Initial thread mask for launch |
| step_i | input | 1 | The instruction at pc_o completes this cycle |
| is_branch_i | input | 1 | That instruction is a conditional branch |
| cond_i | input | WARP (8) | Per-thread branch condition, bit n for thread n |
| target_i | input | PC_W (16) | Branch target address |
| reconv_i | input | PC_W (16) | Reconvergence address of the branch |
| pc_o | output | PC_W (16) | Current shared program counter |
| mask_o | output | WARP (8) | Current execution mask |
| depth_o | output | $clog2(STACK_DEPTH+1) (4) | Number of stack entries in use |
| overflow_o | output | 1 | Sticky stack overflow flag |

## Verification
Every result is registered once. The PC, mask, depth and overflow flag caused by a step or a launch appear on the clock edge that samples that command, and no earlier. The bench changes inputs on the falling edge and reads outputs on the following falling edge, so each read comes exactly one registered edge after its stimulus. A reconvergence switch or pop is triggered by the same step that produces the matching next PC, so it is checked at that same single-edge offset. The bench sets the stack depth to four so that nesting divergent branches five deep can reach the overflow case with eight threads.

// File: rtl/simt_div_pkg.sv
// Package: shared branch classification for the divergence controller.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package simt_div_pkg;

    // Outcome of evaluating one instruction against the active mask
    typedef enum logic [2:0] {
        BR_NONE      = 3'd0,  // not a branch
        BR_IDLE      = 3'd1,  // branch under an all-zero mask
        BR_ALL_TAKEN = 3'd2,  // every active thread takes it
        BR_NO_TAKEN  = 3'd3,  // no active thread takes it
        BR_SPLIT     = 3'd4   // active threads disagree
    } br_kind_e;

endpackage

// File: rtl/simt_branch_eval.sv
// Module: simt_branch_eval
// Classifies a branch against the current execution mask and forms the
// masks of both paths. Purely combinational. Assumes cond_i bits of
// inactive threads may hold any value; they are masked here.
module simt_branch_eval
    import simt_div_pkg::*;
#(
    parameter int WARP = 8
) (
    input  logic            is_branch_i,
    input  logic [WARP-1:0] cond_i,
    input  logic [WARP-1:0] mask_i,
    output br_kind_e        kind_o,
    output logic [WARP-1:0] taken_mask_o,
    output logic [WARP-1:0] alt_mask_o
);

    localparam logic [WARP-1:0] NO_THREADS = '0;

    logic [WARP-1:0] taken_w;
    logic [WARP-1:0] alt_w;

    // Split the active mask into the taken and the deferred group
    always_comb begin
        taken_w = cond_i & mask_i;
        alt_w   = mask_i & ~cond_i;
    end

    // Decide which of the five outcomes applies
    always_comb begin
        if (!is_branch_i) begin
            kind_o = BR_NONE;
        end else if (mask_i == NO_THREADS) begin
            kind_o = BR_IDLE;
        end else if (taken_w == mask_i) begin
            kind_o = BR_ALL_TAKEN;
        end else if (taken_w == NO_THREADS) begin
            kind_o = BR_NO_TAKEN;
        end else begin
            kind_o = BR_SPLIT;
        end
    end

    assign taken_mask_o = taken_w;
    assign alt_mask_o   = alt_w;

endmodule

// File: rtl/simt_reconv_stack.sv
// Module: simt_reconv_stack
// LIFO of reconvergence entries. Each entry holds the reconvergence PC,
// the deferred group's start PC and mask, the mask to restore and a phase
// bit (0: first group running, 1: deferred group running).
// Assumes the caller never pushes when full nor pops/flips when empty,
// and issues at most one of push, flip, pop per cycle. STACK_DEPTH >= 2.
module simt_reconv_stack #(
    parameter int WARP        = 8,
    parameter int PC_W        = 16,
    parameter int STACK_DEPTH = 8,
    localparam int IDX_W      = $clog2(STACK_DEPTH),
    localparam int CNT_W      = $clog2(STACK_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            push_i,
    input  logic [PC_W-1:0] push_reconv_i,
    input  logic [PC_W-1:0] push_alt_pc_i,
    input  logic [WARP-1:0] push_alt_mask_i,
    input  logic [WARP-1:0] push_restore_i,
    input  logic            flip_i,
    input  logic            pop_i,
    output logic [PC_W-1:0] top_reconv_o,
    output logic [PC_W-1:0] top_alt_pc_o,
    output logic [WARP-1:0] top_alt_mask_o,
    output logic [WARP-1:0] top_restore_o,
    output logic            top_second_o,
    output logic            empty_o,
    output logic            full_o,
    output logic [CNT_W-1:0] depth_o
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(STACK_DEPTH);

    logic [PC_W-1:0]  reconv_q  [STACK_DEPTH];
    logic [PC_W-1:0]  alt_pc_q  [STACK_DEPTH];
    logic [WARP-1:0]  alt_mask_q[STACK_DEPTH];
    logic [WARP-1:0]  restore_q [STACK_DEPTH];
    logic [STACK_DEPTH-1:0] second_q;
    logic [CNT_W-1:0] depth_q;
    logic [IDX_W-1:0] top_idx;

    // Occupancy counter
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            depth_q <= '0;
        end else if (push_i) begin
            depth_q <= depth_q + CNT_ONE;
        end else if (pop_i) begin
            depth_q <= depth_q - CNT_ONE;
        end
    end

    // Entry storage: write on push, set phase bit on flip
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STACK_DEPTH; s++) begin
                reconv_q[s]   <= '0;
                alt_pc_q[s]   <= '0;
                alt_mask_q[s] <= '0;
                restore_q[s]  <= '0;
                second_q[s]   <= 1'b0;
            end
        end else begin
            for (int s = 0; s < STACK_DEPTH; s++) begin
                if (push_i && !clear_i && depth_q == CNT_W'(s)) begin
                    reconv_q[s]   <= push_reconv_i;
                    alt_pc_q[s]   <= push_alt_pc_i;
                    alt_mask_q[s] <= push_alt_mask_i;
                    restore_q[s]  <= push_restore_i;
                    second_q[s]   <= 1'b0;
                end else if (flip_i && !clear_i && depth_q == CNT_W'(s + 1)) begin
                    second_q[s]   <= 1'b1;
                end
            end
        end
    end

    // Top-of-stack read port
    always_comb begin
        top_idx        = (depth_q == '0) ? '0 : IDX_W'(depth_q - CNT_ONE);
        top_reconv_o   = reconv_q[top_idx];
        top_alt_pc_o   = alt_pc_q[top_idx];
        top_alt_mask_o = alt_mask_q[top_idx];
        top_restore_o  = restore_q[top_idx];
        top_second_o   = second_q[top_idx];
    end

    assign empty_o = (depth_q == '0);
    assign full_o  = (depth_q == CNT_FULL);
    assign depth_o = depth_q;

    AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o) else $error("push on full stack"); // R8

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i || flip_i) |-> !empty_o) else $error("pop/flip on empty stack"); // R10

    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({push_i, pop_i, flip_i}) <= 1) else $error("stack ops overlap"); // R7

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !clear_i) |=> depth_q == $past(depth_q) + CNT_ONE)
        else $error("push did not grow"); // R4

    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !clear_i) |=> depth_q == $past(depth_q) - CNT_ONE)
        else $error("pop did not shrink"); // R6

    AST_FLIP_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_i && !clear_i) |=> top_second_o) else $error("flip lost"); // R5

endmodule

// File: rtl/simt_diverge_ctrl.sv
// Module: simt_diverge_ctrl (top)
// Owns the shared PC and the execution mask of one warp. On each step it
// classifies the instruction, jumps, falls through or splits the warp,
// and checks the resulting PC against the top reconvergence entry to
// switch to the deferred group or rejoin. Assumes a divergent branch's
// target differs from its reconvergence address and that nested
// conditionals use distinct reconvergence addresses.
module simt_diverge_ctrl
    import simt_div_pkg::*;
#(
    parameter int WARP        = 8,
    parameter int PC_W        = 16,
    parameter int STACK_DEPTH = 8,
    localparam int CNT_W      = $clog2(STACK_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic [PC_W-1:0]  launch_pc_i,
    input  logic [WARP-1:0]  launch_mask_i,
    input  logic             step_i,
    input  logic             is_branch_i,
    input  logic [WARP-1:0]  cond_i,
    input  logic [PC_W-1:0]  target_i,
    input  logic [PC_W-1:0]  reconv_i,
    output logic [PC_W-1:0]  pc_o,
    output logic [WARP-1:0]  mask_o,
    output logic [CNT_W-1:0] depth_o,
    output logic             overflow_o
);

    localparam logic [PC_W-1:0] PC_ONE   = PC_W'(1);
    localparam logic [WARP-1:0] ALL_ON   = '1;

    logic [PC_W-1:0] pc_q,   pc_d;
    logic [WARP-1:0] mask_q, mask_d;
    logic            ovf_q,  ovf_d;
    logic [PC_W-1:0] seq_pc, cand_pc;

    br_kind_e        kind;
    logic [WARP-1:0] taken_mask, alt_mask;

    logic            st_clear, st_push, st_flip, st_pop;
    logic [PC_W-1:0] top_reconv, top_alt_pc;
    logic [WARP-1:0] top_alt_mask, top_restore;
    logic            top_second, st_empty, st_full;
    logic [CNT_W-1:0] st_depth;
    logic            reconv_hit;

    simt_branch_eval #(.WARP(WARP)) eval_i (
        .is_branch_i  (is_branch_i),
        .cond_i       (cond_i),
        .mask_i       (mask_q),
        .kind_o       (kind),
        .taken_mask_o (taken_mask),
        .alt_mask_o   (alt_mask)
    );

    simt_reconv_stack #(
        .WARP        (WARP),
        .PC_W        (PC_W),
        .STACK_DEPTH (STACK_DEPTH)
    ) stack_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .clear_i         (st_clear),
        .push_i          (st_push),
        .push_reconv_i   (reconv_i),
        .push_alt_pc_i   (seq_pc),
        .push_alt_mask_i (alt_mask),
        .push_restore_i  (mask_q),
        .flip_i          (st_flip),
        .pop_i           (st_pop),
        .top_reconv_o    (top_reconv),
        .top_alt_pc_o    (top_alt_pc),
        .top_alt_mask_o  (top_alt_mask),
        .top_restore_o   (top_restore),
        .top_second_o    (top_second),
        .empty_o         (st_empty),
        .full_o          (st_full),
        .depth_o         (st_depth)
    );

    // Next-state selection for PC, mask, overflow and stack commands
    always_comb begin
        seq_pc     = pc_q + PC_ONE;
        cand_pc    = seq_pc;
        pc_d       = pc_q;
        mask_d     = mask_q;
        ovf_d      = ovf_q;
        st_clear   = 1'b0;
        st_push    = 1'b0;
        st_flip    = 1'b0;
        st_pop     = 1'b0;
        reconv_hit = 1'b0;
        if (launch_i) begin
            pc_d     = launch_pc_i;
            mask_d   = launch_mask_i;
            ovf_d    = 1'b0;
            st_clear = 1'b1;
        end else if (step_i) begin
            if (kind == BR_SPLIT && !st_full) begin
                st_push = 1'b1;
                pc_d    = target_i;
                mask_d  = taken_mask;
            end else begin
                if (kind == BR_SPLIT) begin
                    ovf_d = 1'b1;
                end
                if (kind == BR_ALL_TAKEN) begin
                    cand_pc = target_i;
                end
                pc_d = cand_pc;
                if (!st_empty && cand_pc == top_reconv) begin
                    reconv_hit = 1'b1;
                    if (!top_second) begin
                        st_flip = 1'b1;
                        pc_d    = top_alt_pc;
                        mask_d  = top_alt_mask;
                    end else begin
                        st_pop  = 1'b1;
                        mask_d  = top_restore;
                    end
                end
            end
        end
    end

    // Architectural state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            mask_q <= ALL_ON;
            ovf_q  <= 1'b0;
        end else begin
            pc_q   <= pc_d;
            mask_q <= mask_d;
            ovf_q  <= ovf_d;
        end
    end

    assign pc_o       = pc_q;
    assign mask_o     = mask_q;
    assign depth_o    = st_depth;
    assign overflow_o = ovf_q;

    AST_SPLIT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        st_push |=> (pc_q == $past(target_i)) && (mask_q == $past(cond_i & mask_q)))
        else $error("split entry wrong"); // R4

    AST_UNIFORM_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !launch_i && !reconv_hit &&
         (kind == BR_ALL_TAKEN || kind == BR_NO_TAKEN)) |=> $stable(mask_q))
        else $error("uniform branch changed mask"); // R3

    AST_MASK_WITHIN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        !st_empty |-> (mask_q & ~top_restore) == '0)
        else $error("thread escaped enclosing mask"); // R7

    AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !launch_i) |=> ovf_q) else $error("overflow flag dropped"); // R8

    AST_IDLE_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !launch_i && mask_q == '0 && st_empty) |=>
        (mask_q == '0) && (pc_q == $past(pc_q) + PC_ONE))
        else $error("idle branch acted"); // R9

endmodule

// File: tb/simt_diverge_ctrl_tb_top.sv
`timescale 1ns/1ps
module simt_diverge_ctrl_tb_top;

    localparam int WARP  = 8;
    localparam int PC_W  = 16;
    localparam int DEPTH = 4;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic launch_i = 1'b0;
    logic [PC_W-1:0] launch_pc_i = '0;
    logic [WARP-1:0] launch_mask_i = '0;
    logic step_i = 1'b0;
    logic is_branch_i = 1'b0;
    logic [WARP-1:0] cond_i = '0;
    logic [PC_W-1:0] target_i = '0;
    logic [PC_W-1:0] reconv_i = '0;
    logic [PC_W-1:0] pc_o;
    logic [WARP-1:0] mask_o;
    logic [CNT_W-1:0] depth_o;
    logic overflow_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    simt_diverge_ctrl #(.WARP(WARP), .PC_W(PC_W), .STACK_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .launch_i(launch_i), .launch_pc_i(launch_pc_i), .launch_mask_i(launch_mask_i),
        .step_i(step_i), .is_branch_i(is_branch_i), .cond_i(cond_i),
        .target_i(target_i), .reconv_i(reconv_i),
        .pc_o(pc_o), .mask_o(mask_o), .depth_o(depth_o), .overflow_o(overflow_o)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic expect_state(input string req, input int pc, input int mask, input int depth, input int ovf);
        check(req, "pc", int'(pc_o), pc);
        check(req, "mask", int'(mask_o), mask);
        check(req, "depth", int'(depth_o), depth);
        check(req, "overflow", int'(overflow_o), ovf);
    endtask

    // One command: drive on falling edge, sample on the next falling edge
    task automatic do_launch(input int pc, input int mask);
        @(negedge clk);
        launch_i = 1'b1; launch_pc_i = PC_W'(pc); launch_mask_i = WARP'(mask);
        @(negedge clk);
        launch_i = 1'b0;
    endtask

    task automatic do_step(input bit br, input int cond, input int tgt, input int rcv);
        @(negedge clk);
        step_i = 1'b1; is_branch_i = br; cond_i = WARP'(cond);
        target_i = PC_W'(tgt); reconv_i = PC_W'(rcv);
        @(negedge clk);
        step_i = 1'b0; is_branch_i = 1'b0;
    endtask

    task automatic t_reset_and_seq();
        expect_state("R1", 0, 'hFF, 0, 0);
        do_step(0, 0, 0, 0);
        expect_state("R2", 1, 'hFF, 0, 0);
        do_step(0, 'h55, 99, 99);
        expect_state("R2", 2, 'hFF, 0, 0);
    endtask

    task automatic t_uniform();
        do_launch(10, 'h0F);
        expect_state("R11", 10, 'h0F, 0, 0);
        do_step(1, 'hF0, 40, 50);     // only inactive threads vote taken
        expect_state("R3", 11, 'h0F, 0, 0);
        do_step(1, 'hFF, 40, 50);     // all active threads taken
        expect_state("R3", 40, 'h0F, 0, 0);
    endtask

    task automatic t_single_split();
        do_launch(100, 'hFF);
        do_step(1, 'h0F, 200, 300);
        expect_state("R4", 200, 'h0F, 1, 0);
        do_step(0, 0, 0, 0);
        expect_state("R2", 201, 'h0F, 1, 0);
        do_step(1, 'hFF, 300, 0);     // taken group reaches reconvergence
        expect_state("R5", 101, 'hF0, 1, 0);
        do_step(1, 'h00, 300, 0);     // uniform not-taken inside else path
        expect_state("R3", 102, 'hF0, 1, 0);
        do_step(1, 'hFF, 300, 0);     // deferred group reaches reconvergence
        expect_state("R6", 300, 'hFF, 0, 0);
    endtask

    task automatic t_nested();
        do_launch(0, 'hFF);
        do_step(1, 'h0F, 50, 90);
        expect_state("R4", 50, 'h0F, 1, 0);
        do_step(1, 'hF3, 60, 70);     // high bits belong to inactive threads
        expect_state("R7", 60, 'h03, 2, 0);
        do_step(0, 0, 0, 0);
        do_step(1, 'hFF, 70, 0);
        expect_state("R7", 51, 'h0C, 2, 0);
        do_step(1, 'hFF, 70, 0);
        expect_state("R7", 70, 'h0F, 1, 0);
        do_step(1, 'hFF, 90, 0);
        expect_state("R5", 1, 'hF0, 1, 0);
        do_step(1, 'hFF, 90, 0);
        expect_state("R6", 90, 'hFF, 0, 0);
    endtask

    task automatic t_overflow();
        do_launch(0, 'hFF);
        do_step(1, 'h7F, 10, 100);
        do_step(1, 'h3F, 20, 90);
        do_step(1, 'h1F, 30, 80);
        do_step(1, 'h0F, 40, 70);
        expect_state("R4", 40, 'h0F, 4, 0);
        do_step(1, 'h07, 50, 60);     // fifth level on a four-deep stack
        expect_state("R8", 41, 'h0F, 4, 1);
        do_step(0, 0, 0, 0);
        expect_state("R8", 42, 'h0F, 4, 1);
        @(negedge clk);               // launch and step together: launch wins
        launch_i = 1'b1; launch_pc_i = PC_W'(7); launch_mask_i = WARP'('hFF);
        step_i = 1'b1; is_branch_i = 1'b1; cond_i = WARP'('h01); target_i = PC_W'(500);
        @(negedge clk);
        launch_i = 1'b0; step_i = 1'b0; is_branch_i = 1'b0;
        expect_state("R11", 7, 'hFF, 0, 0);
    endtask

    task automatic t_zero_mask();
        do_launch(20, 'h00);
        do_step(1, 'hFF, 99, 30);
        expect_state("R9", 21, 'h00, 0, 0);
    endtask

    task automatic t_empty_stack();
        do_launch(5, 'hFF);
        do_step(1, 'hFF, 7, 7);
        expect_state("R10", 7, 'hFF, 0, 0);
        do_step(0, 0, 0, 0);
        expect_state("R10", 8, 'hFF, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_seq();
        t_uniform();
        t_single_split();
        t_nested();
        t_overflow();
        t_zero_mask();
        t_empty_stack();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule